// File: doc/BRIEF.md
# J1850 Transmit Opcode Sequencer

This block is the byte-level transmit controller that sits in front of a J1850 variable-pulse-width serial coder. Software first loads a data register and then writes an opcode word. Each opcode write is one transmit attempt. The opcode chooses the byte to send, which is either the data register or the node's physical address. It also decides whether a computed CRC byte goes out after that byte. Before the attempt is allowed, the opcode is checked against the current state of the frame.

Accepted bytes go downstream on a valid/ready handshake, one byte per handshake. Opcodes that do not fit the frame state make no attempt and raise an error flag. In-frame-response opcodes can also be gated on the number of message bytes the receiver has counted. The bus-level symbol timing, arbitration and the bit coder are outside this block.

The sequencer has three states. `SQ_READY` waits for an opcode. `SQ_BYTE` presents the selected byte. `SQ_CRC` presents the inverted CRC. The transitions are:
- READY→BYTE on an accepted opcode.
- BYTE→CRC when the byte is taken and a CRC was requested.
- BYTE→READY when the byte is taken and no CRC was requested.
- CRC→READY when the CRC byte is taken.
- any state→BYTE on an accepted opcode, which overrides what is pending.

A separate frame tracker keeps a phase. The phases are `PH_IDLE` (no frame), `PH_MSG` (message open), `PH_EOM` (message closed by a CRC), `PH_IFR3` (data response open) and `PH_CLOSED` (response finished). The phase changes on every accepted opcode and returns to `PH_IDLE` on `frame_end`.

Top module: `vpw_tx_sequencer`

## Requirements
- R1: After reset, `trdy` is 1, `tx_valid` is 0 and `tra_err` is 0.
- R2: The opcode word is decoded as follows: bits 2:0 are the opcode and bits 7:4 are the expected length; bit 3 is ignored. The opcode codes are 0 no-op, 1 MSG, 2 MSG+CRC, 3 IFR1, 4 IFR2, 5 IFR3, 6 IFR3+CRC and 7 reserved.
- R3: An accepted MSG or IFR3 sends exactly one byte, equal to the data register.
- R4: An accepted IFR1 or IFR2 sends exactly one byte, equal to `paddr`.
- R5: MSG+CRC sends the data byte, then the bitwise inverse of a CRC-8. The CRC uses polynomial 0x1D and starts at 0xFF, processing bits MSB first. It covers every byte of the message sent since the message began.
- R6: IFR3+CRC sends the data byte, then the inverted CRC-8 computed over the response bytes only.
- R7: The legal opcodes in each phase are:
  - MSG and MSG+CRC: only in `PH_IDLE` or `PH_MSG`.
  - IFR1 and IFR2: only in `PH_IDLE` or `PH_EOM`.
  - IFR3 and IFR3+CRC: only in `PH_IDLE`, `PH_EOM` or `PH_IFR3`.

  An illegal opcode sends nothing and sets `tra_err`. The next accepted opcode clears `tra_err`.
- R8: An opcode is illegal if the bytes already sent in the frame plus the bytes it needs (1, or 2 with a CRC) would exceed 12.
- R9: With a non-zero length field, an IFR opcode is legal only when `rx_msg_cnt` equals that field. A zero field disables the check.
- R10: On the cycle after an accepted opcode write, `tx_valid` is 1 and `trdy` is 0. `trdy` returns to 1 on the cycle after the last queued byte is taken.
- R11: An opcode write while bytes are still pending is accepted if legal, and it replaces the pending byte and any pending CRC.
- R12: A no-op changes nothing: `trdy`, `tx_valid` and `tra_err` keep their values. The reserved code is illegal.
- R13: `frame_end` returns the frame to `PH_IDLE` with a byte count of zero.
- R14: While `tx_valid` is 1 and `tx_ready` is 0, `tx_data` and `tx_valid` hold unless an opcode is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_wr | input | 1 | Load the transmit data register |
| data_in | input | 8 | Transmit data value |
| op_wr | input | 1 | Opcode write strobe; starts an attempt |
| op_in | input | 8 | Opcode word: {length[3:0], unused, op[2:0]} |
| paddr | input | 8 | Physical address of this node |
| rx_msg_cnt | input | 4 | Message bytes counted by the receiver |
| frame_end | input | 1 | End of frame seen on the bus |
| tx_valid | output | 1 | A byte is offered to the coder |
| tx_data | output | 8 | Offered byte |
| tx_ready | input | 1 | The coder takes the offered byte |
| trdy | output | 1 | A new data/opcode pair may be written |
| tra_err | output | 1 | The last non-no-op opcode was rejected |

## Verification
- Opcode write: its result is registered once. The first byte (or the rejection flag) is due at the falling edge after the rising edge that sampled `op_wr`.
- Bytes after the first: each further byte appears one cycle after the previous one is taken.
- `trdy`: rises one cycle after the last byte is taken.

The bench drives every input on falling edges and samples on falling edges. When it collects bytes, it holds `tx_ready` high and records `tx_data` at each falling edge with `tx_valid` set, until `trdy` returns. Each result is therefore compared in exactly the cycle it is due. The length-gate sweep covers all sixteen field values against a fixed receive count, and the frame-limit case walks the byte count up to the cap.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;

    localparam int unsigned LEN_W    = 4;
    localparam logic [7:0]  CRC_POLY = 8'h1D;
    localparam logic [7:0]  CRC_SEED = 8'hFF;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_MSG      = 3'd1,
        OP_MSG_CRC  = 3'd2,
        OP_IFR1     = 3'd3,
        OP_IFR2     = 3'd4,
        OP_IFR3     = 3'd5,
        OP_IFR3_CRC = 3'd6,
        OP_RSVD     = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_MSG,
        PH_EOM,
        PH_IFR3,
        PH_CLOSED
    } phase_e;

    typedef enum logic [1:0] {
        SQ_READY,
        SQ_BYTE,
        SQ_CRC
    } seq_e;

    // One byte through the CRC-8 shift register, MSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] acc, input logic [7:0] din);
        logic [7:0] c;
        logic       fb;
        c = acc;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ din[i];
            c  = {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
        end
        return c;
    endfunction

endpackage

// File: rtl/vpw_tx_legal.sv
module vpw_tx_legal
    import vpw_tx_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 12,
    localparam int unsigned CW = $clog2(MAX_BYTES + 1)
) (
    input  op_e              op,
    input  logic [LEN_W-1:0] len_req,
    input  logic [LEN_W-1:0] rx_cnt,
    input  phase_e           phase,
    input  logic [CW-1:0]    sent,
    output logic             legal
);

    logic          crc_req;
    logic [CW:0]   total;
    logic          fits;
    logic          len_ok;
    logic          ph_ok;

    assign crc_req = (op == OP_MSG_CRC) || (op == OP_IFR3_CRC);
    assign total   = {1'b0, sent} + (crc_req ? (CW+1)'(2) : (CW+1)'(1));
    assign fits    = total <= (CW+1)'(MAX_BYTES);
    assign len_ok  = (len_req == '0) || (len_req == rx_cnt);

    always_comb begin
        unique case (op)
            OP_MSG, OP_MSG_CRC:   ph_ok = (phase == PH_IDLE) || (phase == PH_MSG);
            OP_IFR1, OP_IFR2:     ph_ok = len_ok && ((phase == PH_IDLE) || (phase == PH_EOM));
            OP_IFR3, OP_IFR3_CRC: ph_ok = len_ok && ((phase == PH_IDLE) || (phase == PH_EOM)
                                                   || (phase == PH_IFR3));
            default:              ph_ok = 1'b0;
        endcase
    end

    assign legal = ph_ok && fits;

endmodule

// File: rtl/vpw_tx_frame.sv
module vpw_tx_frame
    import vpw_tx_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 12,
    localparam int unsigned CW = $clog2(MAX_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  op_e           op,
    input  logic          taken,
    input  logic          frame_end,
    output phase_e        phase,
    output logic [CW-1:0] sent
);

    phase_e phase_d;

    always_comb begin
        phase_d = phase;
        if (frame_end) begin
            phase_d = PH_IDLE;
        end else if (accept) begin
            unique case (op)
                OP_MSG:      phase_d = PH_MSG;
                OP_MSG_CRC:  phase_d = PH_EOM;
                OP_IFR3:     phase_d = PH_IFR3;
                default:     phase_d = PH_CLOSED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            sent  <= '0;
        end else begin
            phase <= phase_d;
            if (frame_end) begin
                sent <= '0;
            end else if (taken && (sent < CW'(MAX_BYTES))) begin
                sent <= sent + CW'(1);
            end
        end
    end

endmodule

// File: rtl/vpw_tx_crc.sv
module vpw_tx_crc
    import vpw_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       absorb,
    input  logic [7:0] din,
    output logic [7:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= CRC_SEED;
        end else if (restart) begin
            crc <= CRC_SEED;
        end else if (absorb) begin
            crc <= crc8_step(crc, din);
        end
    end

endmodule

// File: rtl/vpw_tx_sequencer.sv
module vpw_tx_sequencer
    import vpw_tx_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 12,
    localparam int unsigned CW = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic [7:0]       data_in,
    input  logic             op_wr,
    input  logic [7:0]       op_in,
    input  logic [7:0]       paddr,
    input  logic [LEN_W-1:0] rx_msg_cnt,
    input  logic             frame_end,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    input  logic             tx_ready,
    output logic             trdy,
    output logic             tra_err
);

    seq_e             state_q, state_d;
    logic [7:0]       data_q;
    logic [7:0]       byte_q;
    logic             crc_pend_q;
    logic             err_q;
    op_e              op_w;
    logic [LEN_W-1:0] len_w;
    logic             unused_bit3;
    logic             legal;
    logic             accept;
    logic             reject;
    logic             taken;
    logic             restart;
    phase_e           phase;
    logic [CW-1:0]    frame_cnt;
    logic [7:0]       crc_acc;

    assign op_w        = op_e'(op_in[2:0]);
    assign len_w       = op_in[7:4];
    assign unused_bit3 = op_in[3];

    assign accept  = op_wr && legal;
    assign reject  = op_wr && !legal && (op_w != OP_NOP);
    assign taken   = tx_valid && tx_ready;
    assign restart = accept && ((phase == PH_IDLE) || (phase == PH_EOM));

    vpw_tx_legal #(.MAX_BYTES(MAX_BYTES)) u_legal (
        .op      (op_w),
        .len_req (len_w),
        .rx_cnt  (rx_msg_cnt),
        .phase   (phase),
        .sent    (frame_cnt),
        .legal   (legal)
    );

    vpw_tx_frame #(.MAX_BYTES(MAX_BYTES)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .op        (op_w),
        .taken     (taken),
        .frame_end (frame_end),
        .phase     (phase),
        .sent      (frame_cnt)
    );

    vpw_tx_crc u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .absorb  (taken && (state_q == SQ_BYTE)),
        .din     (byte_q),
        .crc     (crc_acc)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d = SQ_BYTE;
        end else begin
            unique case (state_q)
                SQ_READY: state_d = SQ_READY;
                SQ_BYTE:  if (taken) state_d = crc_pend_q ? SQ_CRC : SQ_READY;
                SQ_CRC:   if (taken) state_d = SQ_READY;
                default:  state_d = SQ_READY;
            endcase
        end
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= SQ_READY;
            data_q     <= '0;
            byte_q     <= '0;
            crc_pend_q <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (data_wr) data_q <= data_in;
            if (accept) begin
                byte_q     <= ((op_w == OP_IFR1) || (op_w == OP_IFR2)) ? paddr : data_q;
                crc_pend_q <= (op_w == OP_MSG_CRC) || (op_w == OP_IFR3_CRC);
                err_q      <= 1'b0;
            end else if (reject) begin
                err_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            SQ_BYTE: begin tx_valid = 1'b1; tx_data = byte_q;   trdy = 1'b0; end
            SQ_CRC:  begin tx_valid = 1'b1; tx_data = ~crc_acc; trdy = 1'b0; end
            default: begin tx_valid = 1'b0; tx_data = byte_q;   trdy = 1'b1; end
        endcase
        tra_err = err_q;
    end

endmodule

// File: rtl/vpw_tx_checker.sv
module vpw_tx_checker #(
    parameter int unsigned MAX_BYTES = 12,
    localparam int unsigned CW = $clog2(MAX_BYTES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_wr,
    input logic [7:0]    op_in,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          tx_ready,
    input logic          trdy,
    input logic          tra_err,
    input logic [CW-1:0] frame_cnt
);

    // R14
    hold_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !op_wr) |=> (tx_valid && $stable(tx_data)));

    // R10
    no_spurious_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy && !op_wr) |=> trdy);

    // R12
    rsvd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && op_in[2:0] == 3'd7) |=> tra_err);

    // R12
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trdy && op_wr && op_in[2:0] == 3'd0) |=> (trdy && $stable(tra_err)));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tra_err) |-> $past(op_wr));

    // R8
    frame_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_cnt <= CW'(MAX_BYTES));

endmodule

bind vpw_tx_sequencer vpw_tx_checker #(.MAX_BYTES(MAX_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_wr     (op_wr),
    .op_in     (op_in),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready),
    .trdy      (trdy),
    .tra_err   (tra_err),
    .frame_cnt (frame_cnt)
);

// File: tb/tb_vpw_tx_sequencer.sv
module tb_vpw_tx_sequencer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_wr = 1'b0;
    logic [7:0] data_in = '0;
    logic       op_wr = 1'b0;
    logic [7:0] op_in = '0;
    logic [7:0] paddr = 8'hA5;
    logic [3:0] rx_msg_cnt = 4'd5;
    logic       frame_end = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;
    logic       trdy;
    logic       tra_err;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;
    logic [7:0] got [0:7];
    int ngot;

    always #2 clk = ~clk;

    vpw_tx_sequencer dut (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
        .op_wr(op_wr), .op_in(op_in), .paddr(paddr), .rx_msg_cnt(rx_msg_cnt),
        .frame_end(frame_end), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .trdy(trdy), .tra_err(tra_err)
    );

    function automatic logic [7:0] ref_crc(input logic [7:0] a, input logic [7:0] b, input int n);
        logic [7:0] c;
        logic [7:0] v [0:1];
        v[0] = a; v[1] = b;
        c = 8'hFF;
        for (int k = 0; k < n; k++) begin
            c = c ^ v[k];
            for (int j = 0; j < 8; j++) c = c[7] ? ((c << 1) ^ 8'h1D) : (c << 1);
        end
        return ~c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_data(input logic [7:0] b);
        data_wr = 1'b1; data_in = b;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic wr_op(input logic [2:0] op, input logic [3:0] len, input logic b3);
        op_wr = 1'b1; op_in = {len, b3, op};
        @(negedge clk);
        op_wr = 1'b0;
    endtask

    task automatic end_frame();
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic collect();
        int guard;
        ngot = 0;
        guard = 0;
        tx_ready = 1'b1;
        while (!trdy && guard < 20) begin
            if (tx_valid && ngot < 8) begin
                got[ngot] = tx_data;
                ngot++;
            end
            @(negedge clk);
            guard++;
        end
        tx_ready = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic [2:0] op, input logic [3:0] len);
        wr_data(d);
        wr_op(op, len, 1'b0);
        collect();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(trdy == 1 && tx_valid == 0 && tra_err == 0, "R1 reset", {trdy, tx_valid, tra_err}, 3'b100);

        // R3 R5 over several data patterns
        for (int p = 0; p < 4; p++) begin
            logic [7:0] a, b;
            a = 8'(8'h13 * (p + 1));
            b = 8'(8'hC4 ^ (p << 3));
            end_frame();
            send(a, 3'd1, 4'd0);
            check(ngot == 1 && got[0] == a, "R3 MSG byte", got[0], a);
            send(b, 3'd2, 4'd0);
            check(ngot == 2 && got[0] == b, "R5 data before CRC", got[0], b);
            check(got[1] == ref_crc(a, b, 2), "R5 CRC", got[1], ref_crc(a, b, 2));
        end

        // R2 bit 3 ignored
        end_frame();
        wr_data(8'h6E);
        wr_op(3'd1, 4'd0, 1'b1);
        collect();
        check(ngot == 1 && got[0] == 8'h6E, "R2 bit3 ignored", got[0], 8'h6E);

        // R4 IFR1 and R7 IFR3 after IFR2
        end_frame();
        send(8'h11, 3'd3, 4'd0);
        check(ngot == 1 && got[0] == paddr, "R4 IFR1 address", got[0], paddr);
        end_frame();
        send(8'h22, 3'd4, 4'd0);
        check(ngot == 1 && got[0] == paddr, "R4 IFR2 address", got[0], paddr);
        send(8'h33, 3'd5, 4'd0);
        check(ngot == 0 && tra_err == 1, "R7 IFR3 after IFR2", {ngot[3:0], tra_err}, 1);

        // R6 response CRC covers only the response section
        end_frame();
        send(8'h51, 3'd1, 4'd0);
        send(8'h52, 3'd2, 4'd0);
        check(tra_err == 0, "R7 error cleared by accept", tra_err, 0);
        send(8'h60, 3'd1, 4'd0);
        check(ngot == 0 && tra_err == 1, "R7 MSG after end of message", ngot, 0);
        send(8'h33, 3'd5, 4'd0);
        check(ngot == 1 && got[0] == 8'h33, "R3 IFR3 byte", got[0], 8'h33);
        send(8'h44, 3'd6, 4'd0);
        check(ngot == 2 && got[0] == 8'h44 && got[1] == ref_crc(8'h33, 8'h44, 2),
              "R6 IFR3 CRC", got[1], ref_crc(8'h33, 8'h44, 2));

        // R12 reserved and no-op
        end_frame();
        send(8'h01, 3'd7, 4'd0);
        check(ngot == 0 && tra_err == 1, "R12 reserved rejected", tra_err, 1);
        wr_op(3'd0, 4'd0, 1'b0);
        check(trdy == 1 && tx_valid == 0 && tra_err == 1, "R12 no-op quiet", {trdy, tx_valid, tra_err}, 3'b101);

        // R8 frame limit, R13 frame end
        end_frame();
        for (int i = 0; i < 11; i++) send(8'(i), 3'd1, 4'd0);
        send(8'hEE, 3'd2, 4'd0);
        check(ngot == 0 && tra_err == 1, "R8 CRC past 12", ngot, 0);
        send(8'hEF, 3'd1, 4'd0);
        check(ngot == 1 && tra_err == 0, "R8 twelfth byte", ngot, 1);
        send(8'hF0, 3'd1, 4'd0);
        check(ngot == 0 && tra_err == 1, "R8 thirteenth byte", ngot, 0);
        end_frame();
        send(8'hF1, 3'd1, 4'd0);
        check(ngot == 1 && got[0] == 8'hF1, "R13 frame end reopens", got[0], 8'hF1);

        // R9 length gate sweep
        for (int m = 0; m < 16; m++) begin
            bit exp_ok;
            exp_ok = (m == 0) || (m == 5);
            end_frame();
            send(8'h77, 3'd3, 4'(m));
            check((ngot == 1) == exp_ok && tra_err == !exp_ok, "R9 length gate", ngot, exp_ok);
        end

        // R10 timing and R11 override
        end_frame();
        wr_data(8'h9A);
        wr_op(3'd1, 4'd0, 1'b0);
        check(tx_valid == 1 && trdy == 0 && tx_data == 8'h9A, "R10 byte next cycle", tx_data, 8'h9A);
        @(negedge clk);
        check(tx_valid == 1 && tx_data == 8'h9A, "R14 held while stalled", tx_data, 8'h9A);
        wr_data(8'h3C);
        wr_op(3'd1, 4'd0, 1'b0);
        check(tx_valid == 1 && tx_data == 8'h3C, "R11 override", tx_data, 8'h3C);
        collect();
        check(ngot == 1 && got[0] == 8'h3C && trdy == 1, "R11 only new byte, R10 trdy back", got[0], 8'h3C);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule